// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block draws a 32x32 cursor on top of a raster pixel stream. Each cursor pixel carries a 2-bit code built from an AND-mask bit and an XOR-mask bit. The code picks one of two cursor colors, lets the background through, or inverts the background bitwise. Software moves the cursor by writing only an X and a Y position. The pattern itself stays in memory. Several patterns can live in memory at once, and one is chosen by pointing the start offset at it.

Before each display line, the block works out which cursor row that line needs. During horizontal blanking it reads the two 32-bit mask words of that row through a simple word-read port and holds them in a 64-bit line buffer. It then composites each incoming 24-bit pixel with one register stage of latency. The start offset and the X/Y position are shadow registers. Values written to them take effect only at the next frame-start pulse.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, `outValid` and `memRdEn` are 0.
- R2: Inside the cursor window on a fetched line, a pixel with code {AND,XOR}=00 is output as `color0`.
- R3: Inside the window, code 01 outputs `color1`.
- R4: Inside the window, code 10 outputs the background pixel `pixRgb` unchanged.
- R5: Inside the window, code 11 outputs the bitwise inverse of `pixRgb`.
- R6: Cursor row r is read from word addresses base+2r (the left 16 pixels) and base+2r+1 (the right 16 pixels). In each word, bits 31:16 are the AND bits and bits 15:0 are the XOR bits. Cursor column c in 0..15 uses bit 15-c of its half, so the leftmost pixel sits in the most significant bit.
- R7: The cursor window covers raster columns X..X+31 and lines Y..Y+31, compared unsigned at full width. Every pixel outside it passes through unchanged. A cursor that reaches past the right or bottom edge is clipped and never wraps.
- R8: `patBase`, `posX` and `posY` are sampled only on a `frameStart` cycle. Writes between frame starts have no effect until the next one. `color0` and `color1` are used live.
- R9: A `lineStart` pulse with a `lineY` inside the window starts exactly two reads, in address order, one per accepted cycle (`memRdEn` and `memReady` both high). Read data is expected on `memRdData` in the cycle after acceptance. Lines outside the window issue no reads.
- R10: No read is issued, and no read data is accepted, in or after the first `pixValid` cycle of a line. If the second word was not captured before that cycle, the whole line shows no cursor.
- R11: `outValid` and `outRgb` are the registered result of the previous cycle's `pixValid` and pixel, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse before the first line of a frame; loads the shadow registers |
| lineStart | input | 1 | One-cycle pulse at the start of horizontal blanking |
| lineY | input | 12 | Raster line that follows this `lineStart` |
| pixX | input | 12 | Raster column of the current pixel |
| pixValid | input | 1 | Current pixel is active video |
| pixRgb | input | 24 | Background pixel |
| posX | input | 12 | Cursor left column (shadowed) |
| posY | input | 12 | Cursor top line (shadowed) |
| patBase | input | 14 | Pattern start as a 32-bit word index (shadowed) |
| color0 | input | 24 | Cursor color for code 00 |
| color1 | input | 24 | Cursor color for code 01 |
| memReady | input | 1 | Memory accepts the read request this cycle |
| memRdData | input | 32 | Read data, valid the cycle after acceptance |
| memRdEn | output | 1 | Read request |
| memAddr | output | 14 | Word address of the read request |
| outRgb | output | 24 | Composited pixel |
| outValid | output | 1 | `pixValid` delayed by one cycle |

## Verification
The hardest case to reach is a race at the start of active video. The second mask word can land one cycle before the first active pixel, or exactly on it. The outcome decides whether the cursor appears on that whole line. The stimulus gets there in three ways. It sets the blanking length to three cycles, which just completes the fetch, and to two cycles, which just misses it. It also holds `memReady` low through blanking. Meanwhile a reference model tracks accepted reads at the ports and predicts line by line whether the cursor appears. A second hard case is a register write in the middle of a frame. It is checked by moving the base and position halfway down a frame and confirming that the read addresses stay on the old pattern until the next `frameStart`.

// File: rtl/cursor_pkg.sv
`timescale 1ns/1ps
package cursor_pkg;
  localparam int CAP_IDX_W = 4;

  typedef struct packed {
    logic                 cap;
    logic [CAP_IDX_W-1:0] capIdx;
    logic                 lineGo;
  } curStrobe_t;

  typedef enum logic [1:0] {
    CODE_COLOR0 = 2'b00,
    CODE_COLOR1 = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } curCode_e;
endpackage

// File: rtl/cursor_ctl.sv
`timescale 1ns/1ps
module cursor_ctl
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 14,
  parameter int CUR_DIM = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [COORD_W-1:0] lineY,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [ADDR_W-1:0]  patBase,
  input  logic               memReady,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [COORD_W-1:0] curX,
  output curStrobe_t         stb
);
  localparam int WPL   = CUR_DIM / 16;
  localparam int CNT_W = $clog2(WPL + 1);

  logic [ADDR_W-1:0]  baseQ, effBase, rowBaseQ;
  logic [COORD_W-1:0] xQ, yQ, effY, rowDiff;
  logic               inRange, seenQ, locked, fetchQ, accQ, lineOkQ;
  logic               accept, cap;
  logic [CNT_W-1:0]   issueCnt, capCnt;

  // shadow values: the frame-start cycle already sees the new ones
  assign effBase = frameStart ? patBase : baseQ;
  assign effY    = frameStart ? posY : yQ;
  assign rowDiff = lineY - effY;
  assign inRange = (lineY >= effY) && (rowDiff < COORD_W'(CUR_DIM));

  assign locked  = seenQ | pixValid;
  assign memRdEn = fetchQ & ~locked;
  assign accept  = memRdEn & memReady;
  assign memAddr = rowBaseQ + ADDR_W'(issueCnt);
  assign cap     = accQ & ~locked & ~lineStart;

  assign curX       = xQ;
  assign stb.cap    = cap;
  assign stb.capIdx = CAP_IDX_W'(capCnt);
  assign stb.lineGo = lineOkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      xQ    <= '0;
      yQ    <= '0;
    end else if (frameStart) begin
      baseQ <= patBase;
      xQ    <= posX;
      yQ    <= posY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenQ    <= 1'b0;
      fetchQ   <= 1'b0;
      accQ     <= 1'b0;
      lineOkQ  <= 1'b0;
      issueCnt <= '0;
      capCnt   <= '0;
      rowBaseQ <= '0;
    end else if (lineStart) begin
      seenQ    <= 1'b0;
      fetchQ   <= inRange;
      accQ     <= 1'b0;
      lineOkQ  <= 1'b0;
      issueCnt <= '0;
      capCnt   <= '0;
      rowBaseQ <= effBase + ADDR_W'(rowDiff) * ADDR_W'(WPL);
    end else begin
      if (pixValid) seenQ <= 1'b1;
      accQ <= accept;
      if (accept) begin
        issueCnt <= issueCnt + 1'b1;
        if (issueCnt == CNT_W'(WPL - 1)) fetchQ <= 1'b0;
      end
      if (locked) fetchQ <= 1'b0;
      if (cap) begin
        capCnt <= capCnt + 1'b1;
        if (capCnt == CNT_W'(WPL - 1)) lineOkQ <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cursor_dp.sv
`timescale 1ns/1ps
module cursor_dp
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int COLOR_W = 24,
  parameter int CUR_DIM = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  curStrobe_t         stb,
  input  logic [31:0]        memRdData,
  input  logic [COORD_W-1:0] curX,
  input  logic [COORD_W-1:0] pixX,
  input  logic               pixValid,
  input  logic [COLOR_W-1:0] pixRgb,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  output logic [COLOR_W-1:0] outRgb,
  output logic               outValid
);
  localparam int WPL   = CUR_DIM / 16;
  localparam int COL_W = $clog2(CUR_DIM);

  logic [WPL-1:0][31:0] lineBuf;
  logic [COORD_W-1:0]   colOff;
  logic                 inWin, andBit, xorBit;
  logic [31:0]          selWord;
  logic [3:0]           bitIdx;
  logic [COLOR_W-1:0]   nextRgb;

  always_ff @(posedge clk) begin
    for (int i = 0; i < WPL; i++) begin
      if (stb.cap && stb.capIdx == CAP_IDX_W'(i)) lineBuf[i] <= memRdData;
    end
  end

  assign colOff  = pixX - curX;
  assign inWin   = stb.lineGo && (pixX >= curX) && (colOff < COORD_W'(CUR_DIM));
  assign selWord = lineBuf[colOff[COL_W-1:4]];
  assign bitIdx  = 4'hF - colOff[3:0];
  assign andBit  = selWord[5'd16 + {1'b0, bitIdx}];
  assign xorBit  = selWord[{1'b0, bitIdx}];

  always_comb begin
    nextRgb = pixRgb;
    if (inWin) begin
      case (curCode_e'({andBit, xorBit}))
        CODE_COLOR0: nextRgb = color0;
        CODE_COLOR1: nextRgb = color1;
        CODE_CLEAR:  nextRgb = pixRgb;
        CODE_INVERT: nextRgb = ~pixRgb;
        default:     nextRgb = pixRgb;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= pixValid;
      outRgb   <= nextRgb;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 14,
  parameter int COLOR_W = 24,
  parameter int CUR_DIM = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [COORD_W-1:0] lineY,
  input  logic [COORD_W-1:0] pixX,
  input  logic               pixValid,
  input  logic [COLOR_W-1:0] pixRgb,
  input  logic [COORD_W-1:0] posX,
  input  logic [COORD_W-1:0] posY,
  input  logic [ADDR_W-1:0]  patBase,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  input  logic               memReady,
  input  logic [31:0]        memRdData,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [COLOR_W-1:0] outRgb,
  output logic               outValid
);
  curStrobe_t         ctlStb;
  logic [COORD_W-1:0] curX;

  cursor_ctl #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .CUR_DIM(CUR_DIM)) u_ctl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .lineY(lineY), .pixValid(pixValid), .posX(posX), .posY(posY),
    .patBase(patBase), .memReady(memReady), .memRdEn(memRdEn),
    .memAddr(memAddr), .curX(curX), .stb(ctlStb)
  );

  cursor_dp #(.COORD_W(COORD_W), .COLOR_W(COLOR_W), .CUR_DIM(CUR_DIM)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .memRdData(memRdData),
    .curX(curX), .pixX(pixX), .pixValid(pixValid), .pixRgb(pixRgb),
    .color0(color0), .color1(color1), .outRgb(outRgb), .outValid(outValid)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
`timescale 1ns/1ps
module cursor_overlay_chk #(
  parameter int ADDR_W  = 14,
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               lineStart,
  input logic               pixValid,
  input logic [COLOR_W-1:0] pixRgb,
  input logic               memReady,
  input logic               memRdEn,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [COLOR_W-1:0] outRgb,
  input logic               outValid,
  input logic               capStb,
  input logic               lineGo
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) pixValid |=> outValid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN) !pixValid |=> !outValid); // R11
  AST_NO_LATE_READ: assert property (@(posedge clk) disable iff (!rstN) memRdEn |-> !pixValid); // R10
  AST_NO_LATE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN) capStb |-> !pixValid); // R10
  AST_PASS_UNFETCHED: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !lineGo) |=> (outRgb == $past(pixRgb))); // R7
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memReady && !lineStart) |=> (!memRdEn || memAddr == $past(memAddr) + ADDR_W'(1))); // R9
endmodule

bind cursor_overlay cursor_overlay_chk #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .pixValid(pixValid), .pixRgb(pixRgb),
  .memReady(memReady), .memRdEn(memRdEn), .memAddr(memAddr), .outRgb(outRgb),
  .outValid(outValid), .capStb(ctlStb.cap), .lineGo(ctlStb.lineGo)
);

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int SCR_W = 64;
  localparam int SCR_H = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 0, lineStart = 0, pixValid = 0, memReady = 0;
  logic [11:0] lineY = 0, pixX = 0, posX = 0, posY = 0;
  logic [13:0] patBase = 0;
  logic [23:0] pixRgb = 0, color0 = 0, color1 = 0;
  logic [31:0] memRdData = 0;
  logic        memRdEn, outValid;
  logic [13:0] memAddr;
  logic [23:0] outRgb;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .lineY(lineY), .pixX(pixX), .pixValid(pixValid), .pixRgb(pixRgb),
    .posX(posX), .posY(posY), .patBase(patBase), .color0(color0), .color1(color1),
    .memReady(memReady), .memRdData(memRdData), .memRdEn(memRdEn),
    .memAddr(memAddr), .outRgb(outRgb), .outValid(outValid)
  );

  int nChecks = 0, nFails = 0, cyc = 0;
  logic [31:0] mem [256];

  // memory model: one-cycle read latency, garbage otherwise
  always @(posedge clk) begin
    if (memRdEn && memReady) memRdData <= mem[memAddr[7:0]];
    else memRdData <= $urandom;
  end

  // behavioural reference model
  int    mBase, mX, mY, mRowBase, accCnt, col, bitPos, eb, ey;
  bit    mInLine, mSeen, mLineOk, cap2Pend, expV, lockNow, acc;
  logic [23:0] expRgb;
  logic [31:0] w;
  string expTag;

  always @(posedge clk) begin
    if (!rstN) begin
      mBase = 0; mX = 0; mY = 0; mRowBase = 0; accCnt = 0;
      mInLine = 0; mSeen = 0; mLineOk = 0; cap2Pend = 0; expV = 0;
      expRgb = 0; expTag = "R11";
    end else begin
      expV = pixValid; expRgb = pixRgb; expTag = "R7";
      col = int'(pixX) - mX;
      if (pixValid && mInLine && col >= 0 && col < 32) begin
        if (!mLineOk) expTag = "R10";
        else begin
          w = mem[(mRowBase + col / 16) & 255];
          bitPos = 15 - (col % 16);
          case ({w[16 + bitPos], w[bitPos]})
            2'b00: begin expRgb = color0; expTag = "R2"; end
            2'b01: begin expRgb = color1; expTag = "R3"; end
            2'b10: begin expRgb = pixRgb; expTag = "R4"; end
            default: begin expRgb = ~pixRgb; expTag = "R5"; end
          endcase
        end
      end
      lockNow = mSeen || pixValid;
      acc = memRdEn && memReady;
      if (lineStart) begin
        eb = frameStart ? int'(patBase) : mBase;
        ey = frameStart ? int'(posY) : mY;
        mInLine = (int'(lineY) >= ey) && (int'(lineY) - ey < 32);
        mRowBase = eb + (int'(lineY) - ey) * 2;
        accCnt = 0; mSeen = 0; mLineOk = 0; cap2Pend = 0;
      end else begin
        if (cap2Pend && !lockNow) mLineOk = 1;
        cap2Pend = acc && accCnt == 1;
        if (acc) accCnt++;
        if (pixValid) mSeen = 1;
      end
      if (frameStart) begin
        mBase = int'(patBase); mX = int'(posX); mY = int'(posY);
      end
    end
  end

  bit running = 0;
  bit expRd;
  always @(negedge clk) begin
    if (rstN && running) begin
      nChecks++;
      if (outValid !== expV) begin
        nFails++;
        $display("FAIL R11: outValid=%0b expected %0b", outValid, expV);
      end
      if (expV) begin
        nChecks++;
        if (outRgb !== expRgb) begin
          nFails++;
          $display("FAIL %s: outRgb=%h expected %h", expTag, outRgb, expRgb);
        end
      end
      expRd = mInLine && !(mSeen || pixValid) && accCnt < 2;
      nChecks++;
      if (memRdEn !== expRd) begin
        nFails++;
        $display("FAIL R9/R10: memRdEn=%0b expected %0b", memRdEn, expRd);
      end
      if (memRdEn && expRd) begin
        nChecks++;
        if (int'(memAddr) != mRowBase + accCnt) begin
          nFails++;
          $display("FAIL R6/R8/R9: memAddr=%h expected %h", memAddr, 14'(mRowBase + accCnt));
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // mode 0: ready in blanking; mode 1: ready held low in blanking
  task automatic runLine(input int y, input int hb, input int mode);
    lineStart = 1; lineY = 12'(y); memReady = (mode != 1); pixValid = 0;
    tick();
    lineStart = 0;
    for (int i = 0; i < hb; i++) tick();
    for (int x = 0; x < SCR_W; x++) begin
      pixValid = 1; pixX = 12'(x); pixRgb = 24'($urandom); memReady = 1'($urandom);
      tick();
    end
    pixValid = 0;
    tick();
  endtask

  task automatic runFrame(input int kind);
    frameStart = 1;
    tick();
    frameStart = 0;
    tick();
    for (int y = 0; y < SCR_H; y++) begin
      if (kind == 1 && y == 20) begin
        // R8: mid-frame writes must wait for the next frame start
        patBase = 14'h80; posX = 12'd45; posY = 12'd20;
        color0 = 24'h00FF00; color1 = 24'hFF00FF;
      end
      if (kind == 3) begin
        case (y % 4)
          1: runLine(y, 8, 1);   // R10 starved fetch
          2: runLine(y, 2, 0);   // R10 second word lands on first pixel
          3: runLine(y, 3, 0);   // just in time
          default: runLine(y, 8, 0);
        endcase
      end else runLine(y, 8, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    color0 = 24'h102030; color1 = 24'hE0D0C0;
    repeat (3) tick();
    // R1: reset state
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || memRdEn !== 1'b0) begin
      nFails++;
      $display("FAIL R1: outValid=%0b memRdEn=%0b expected 0 0", outValid, memRdEn);
    end
    tick();
    rstN = 1;
    running = 1;
    tick();
    patBase = 14'h40; posX = 12'd10; posY = 12'd4;
    runFrame(1);
    runFrame(2);                       // R7 clipped right and bottom
    patBase = 14'h40; posX = 12'd0; posY = 12'd0;
    runFrame(3);
    patBase = 14'h80; posX = 12'd62; posY = 12'd37;
    runFrame(4);                       // R7 two columns, three lines
    running = 0;
    summary();
    $finish;
  end
endmodule